// File: doc/BRIEF.md
# Condition Flag and Predicate Unit

This unit keeps the four condition flags of a processor execute stage: negative, zero, carry and overflow. Each cycle it can accept one operation with two operands. It evaluates the instruction's 4-bit condition against the flags it currently holds. If the condition passes, it computes the result and, where the operation calls for it, the new flags. If the condition fails, nothing is written. Decode, the register file and memory sit outside the unit.

The supported operations are add, subtract and reverse subtract, each with and without carry-in; the bitwise AND, exclusive-OR, OR and bit-clear; move and move-inverted of the second operand; and multiply. On subtraction the carry flag means "no borrow". The bitwise operations and multiply leave some flags alone. A compare or test request always updates the flags and never overwrites the result. The condition pass/fail output depends only on the condition field and the held flags, so the pipeline can use it in the same cycle. The result and the flags change on the clock edge that accepts the operation.

Top module: `cond_flag_unit`

## Requirements
- R1: While rst_n is low at a clock edge, the result clears to 0 and all four flags clear to 0. The flags port is ordered N at bit 3, Z at bit 2, C at bit 1 and V at bit 0.
- R2: exec_en is combinational from cond and the held flags: 0 Z set, 1 Z clear, 2 C set, 3 C clear, 4 N set, 5 N clear, 6 V set, 7 V clear, 8 C set and Z clear, 9 C clear or Z set, 10 N equal to V, 11 N differing from V, 12 Z clear and N equal to V, 13 Z set or N differing from V, 14 always true, 15 always false.
- R3: For op_sel 0..5 the result is, in order: lhs+rhs, lhs+rhs+C, lhs−rhs, lhs−rhs−(1−C), rhs−lhs, rhs−lhs−(1−C), all modulo 2^W. When flags are written, N is the result MSB and Z is set when the result is zero.
- R4: For the add forms, C is the carry out of bit W−1. For the subtract forms, C is 1 when no borrow occurs, meaning the minuend is at least the subtrahend plus the borrow-in.
- R5: For the arithmetic forms, V is set exactly when the true signed result lies outside the W-bit two's-complement range.
- R6: For op_sel 6..11 (AND, XOR, OR, lhs AND NOT rhs, rhs, NOT rhs), a flag write sets N and Z from the result. C takes shift_carry when shift_used is 1 and otherwise keeps its value. V never changes.
- R7: For op_sel 12 the result is the low W bits of lhs×rhs. A flag write updates N and Z only; C and V keep their values.
- R8: When cmp_test is 1 and the operation commits, the flags are written as for a flag-setting operation, and the result keeps its previous value.
- R9: When op_valid is 0, or exec_en is 0, the result and the flags keep their values at the next edge.
- R10: A committed operation with set_flags and cmp_test both 0 writes the result and leaves all four flags unchanged.
- R11: op_sel codes 13..15 behave as the move of rhs, including the flag rules of R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | An operation is presented this cycle |
| op_sel | input | 4 | Operation code (see R3, R6, R7, R11) |
| lhs | input | W | First operand |
| rhs | input | W | Second operand, already shifted |
| shift_carry | input | 1 | Carry out of the operand shifter |
| shift_used | input | 1 | The second operand went through a shift |
| set_flags | input | 1 | Request to update the flags |
| cmp_test | input | 1 | Compare/test: write the flags, discard the result |
| cond | input | 4 | Condition field (see R2) |
| result | output | W | Registered result |
| flags | output | 4 | Registered flags {N,Z,C,V} |
| exec_en | output | 1 | The condition passes against the held flags |

## Verification
A wrong flag bit inside the unit first shows up on exec_en, in the same cycle as the next operation's condition that reads that flag. One cycle later it shows up on the result of the next add-with-carry or subtract-with-carry, because those operations feed C back into the sum. A missed or extra write enable shows on the result or flags port one edge after the operation that should, or should not, have committed. The bench uses a narrow datapath so it can cover every operand pair for every op code while the condition field cycles. This lets every predicate see flag states that earlier operations produced.

// File: rtl/cfu_pkg.sv
// Package: operation codes and flag bit positions shared by the
// condition flag unit, its sub-blocks and its checker.
package cfu_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBC = 4'd3,
        OP_RSB = 4'd4,
        OP_RSC = 4'd5,
        OP_AND = 4'd6,
        OP_EOR = 4'd7,
        OP_ORR = 4'd8,
        OP_BIC = 4'd9,
        OP_MOV = 4'd10,
        OP_MVN = 4'd11,
        OP_MUL = 4'd12
    } cfu_op_e;

    localparam int FLG_N = 3;
    localparam int FLG_Z = 2;
    localparam int FLG_C = 1;
    localparam int FLG_V = 0;

    localparam logic [3:0] LAST_ARITH = 4'd5;

endpackage

// File: rtl/cfu_cond_eval.sv
// Module: cfu_cond_eval
// Turns a 4-bit condition field and the current {N,Z,C,V} into a
// pass/fail bit. Purely combinational. Assumes the flag ordering of cfu_pkg.
module cfu_cond_eval
    import cfu_pkg::*;
(
    input  logic [3:0] cond,
    input  logic [3:0] flags,
    output logic       pass
);
    logic n, z, c, v;
    assign n = flags[FLG_N];
    assign z = flags[FLG_Z];
    assign c = flags[FLG_C];
    assign v = flags[FLG_V];

    // Decode the condition field into a single predicate
    always_comb begin
        unique case (cond)
            4'd0:    pass = z;
            4'd1:    pass = !z;
            4'd2:    pass = c;
            4'd3:    pass = !c;
            4'd4:    pass = n;
            4'd5:    pass = !n;
            4'd6:    pass = v;
            4'd7:    pass = !v;
            4'd8:    pass = c && !z;
            4'd9:    pass = !c || z;
            4'd10:   pass = (n == v);
            4'd11:   pass = (n != v);
            4'd12:   pass = !z && (n == v);
            4'd13:   pass = z || (n != v);
            4'd14:   pass = 1'b1;
            default: pass = 1'b0;
        endcase
    end
endmodule

// File: rtl/cfu_datapath.sv
// Module: cfu_datapath
// Computes the candidate result and candidate flags for one operation.
// Arithmetic uses a single W+1 bit adder: the subtract forms invert one
// operand and use the carry-in, so the adder carry-out is already the
// "no borrow" flag. Assumes op codes 13..15 are moves of rhs.
module cfu_datapath
    import cfu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [3:0]   op_sel,
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    input  logic         shift_carry,
    input  logic         shift_used,
    input  logic [3:0]   flags_in,
    output logic [W-1:0] res,
    output logic [3:0]   flags_out
);
    localparam int MSB = W - 1;

    cfu_op_e      op;
    logic         c_in;
    logic         is_arith;
    logic [W-1:0] add_a, add_b;
    logic         add_cin;
    logic [W:0]   sum;
    logic         v_arith;
    logic [W-1:0] mul_lo;

    assign op       = cfu_op_e'(op_sel);
    assign c_in     = flags_in[FLG_C];
    assign is_arith = (op_sel <= LAST_ARITH);

    // Select adder inputs: inversion plus carry-in realises each subtract form
    always_comb begin
        add_a   = lhs;
        add_b   = rhs;
        add_cin = 1'b0;
        case (op)
            OP_ADC: add_cin = c_in;
            OP_SUB: begin add_b = ~rhs; add_cin = 1'b1; end
            OP_SBC: begin add_b = ~rhs; add_cin = c_in; end
            OP_RSB: begin add_a = rhs; add_b = ~lhs; add_cin = 1'b1; end
            OP_RSC: begin add_a = rhs; add_b = ~lhs; add_cin = c_in; end
            default: ;
        endcase
    end

    assign sum     = {1'b0, add_a} + {1'b0, add_b} + {{W{1'b0}}, add_cin};
    assign v_arith = (add_a[MSB] == add_b[MSB]) && (sum[MSB] != add_a[MSB]);
    assign mul_lo  = lhs * rhs;

    // Pick the result for the operation class
    always_comb begin
        case (op)
            OP_AND:  res = lhs & rhs;
            OP_EOR:  res = lhs ^ rhs;
            OP_ORR:  res = lhs | rhs;
            OP_BIC:  res = lhs & ~rhs;
            OP_MVN:  res = ~rhs;
            OP_MUL:  res = mul_lo;
            OP_MOV:  res = rhs;
            default: res = is_arith ? sum[W-1:0] : rhs;
        endcase
    end

    // Form the candidate flags; partial-update classes keep C and/or V
    always_comb begin
        flags_out[FLG_N] = res[MSB];
        flags_out[FLG_Z] = (res == '0);
        if (is_arith) begin
            flags_out[FLG_C] = sum[W];
            flags_out[FLG_V] = v_arith;
        end else if (op == OP_MUL) begin
            flags_out[FLG_C] = c_in;
            flags_out[FLG_V] = flags_in[FLG_V];
        end else begin
            flags_out[FLG_C] = shift_used ? shift_carry : c_in;
            flags_out[FLG_V] = flags_in[FLG_V];
        end
    end
endmodule

// File: rtl/cond_flag_unit.sv
// Module: cond_flag_unit (top)
// Holds the result and the {N,Z,C,V} flags, gates writes with the
// condition predicate, and routes compare/test to a flag-only write.
// Assumes the caller presents one operation per cycle with op_valid.
module cond_flag_unit
    import cfu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         op_valid,
    input  logic [3:0]   op_sel,
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    input  logic         shift_carry,
    input  logic         shift_used,
    input  logic         set_flags,
    input  logic         cmp_test,
    input  logic [3:0]   cond,
    output logic [W-1:0] result,
    output logic [3:0]   flags,
    output logic         exec_en
);
    logic [W-1:0] result_q;
    logic [3:0]   flags_q;
    logic [W-1:0] dp_res;
    logic [3:0]   dp_flags;
    logic         commit, res_we, flag_we;

    cfu_cond_eval u_cond (
        .cond  (cond),
        .flags (flags_q),
        .pass  (exec_en)
    );

    cfu_datapath #(.W(W)) u_dp (
        .op_sel      (op_sel),
        .lhs         (lhs),
        .rhs         (rhs),
        .shift_carry (shift_carry),
        .shift_used  (shift_used),
        .flags_in    (flags_q),
        .res         (dp_res),
        .flags_out   (dp_flags)
    );

    assign commit  = op_valid && exec_en;
    assign res_we  = commit && !cmp_test;
    assign flag_we = commit && (set_flags || cmp_test);

    // Result and flag registers with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            flags_q  <= '0;
        end else begin
            if (res_we)  result_q <= dp_res;
            if (flag_we) flags_q  <= dp_flags;
        end
    end

    assign result = result_q;
    assign flags  = flags_q;
endmodule

// File: rtl/cfu_checker.sv
// Module: cfu_checker
// Port-level temporal checks for cond_flag_unit, attached by bind.
module cfu_checker
    import cfu_pkg::*;
#(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         op_valid,
    input logic [3:0]   op_sel,
    input logic         set_flags,
    input logic         cmp_test,
    input logic [3:0]   cond,
    input logic [W-1:0] result,
    input logic [3:0]   flags,
    input logic         exec_en
);
    AST_NEVER_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (cond == 4'd15) |-> !exec_en);                                     // R2
    AST_ALWAYS_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (cond == 4'd14) |-> exec_en);                                      // R2
    AST_NO_COMMIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid || !exec_en) |=> ($stable(result) && $stable(flags)));  // R9
    AST_CMP_KEEPS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && cmp_test) |=> $stable(result));                       // R8
    AST_MUL_KEEPS_CV: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == OP_MUL) |=> $stable(flags[1:0]));          // R7
    AST_LOGIC_KEEPS_V: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel > LAST_ARITH) |=> $stable(flags[FLG_V]));      // R6
    AST_NO_REQ_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !set_flags && !cmp_test) |=> $stable(flags));         // R10
endmodule

bind cond_flag_unit cfu_checker #(.W(W)) u_cfu_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_sel    (op_sel),
    .set_flags (set_flags),
    .cmp_test  (cmp_test),
    .cond      (cond),
    .result    (result),
    .flags     (flags),
    .exec_en   (exec_en)
);

// File: tb/test_cond_flag_unit.sv
`timescale 1ns/1ps
// Bench: sweeps every op code and every operand pair on a 4-bit datapath,
// with a flag model computed from integer arithmetic.
module test_cond_flag_unit;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         op_valid, shift_carry, shift_used, set_flags, cmp_test;
    logic [3:0]   op_sel, cond;
    logic [W-1:0] lhs, rhs, result;
    logic [3:0]   flags;
    logic         exec_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Model state
    int m_res;
    int mn, mz, mc, mv;

    always #2.5 clk = ~clk;

    cond_flag_unit #(.W(W)) i_cond_flag_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .lhs(lhs), .rhs(rhs), .shift_carry(shift_carry), .shift_used(shift_used),
        .set_flags(set_flags), .cmp_test(cmp_test), .cond(cond),
        .result(result), .flags(flags), .exec_en(exec_en)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int pred(input int c);
        case (c)
            0: return mz;             1: return !mz;
            2: return mc;             3: return !mc;
            4: return mn;             5: return !mn;
            6: return mv;             7: return !mv;
            8: return mc && !mz;      9: return !mc || mz;
            10: return mn == mv;      11: return mn != mv;
            12: return !mz && (mn == mv);
            13: return mz || (mn != mv);
            14: return 1;
            default: return 0;
        endcase
    endfunction

    function automatic int sgn(input int x);
        return (x >= 8) ? x - 16 : x;
    endfunction

    // One operation: drive, check exec_en, clock, check the outputs
    task automatic run_op(input int op, input int a, input int b, input int vld,
                          input int sf, input int ct, input int su, input int sc,
                          input int cd);
        int r, cn, vn, us, ss, x, y, bw, commit, wr_f;
        string rtag;
        op_valid = 1'(vld); op_sel = 4'(op); lhs = 4'(a); rhs = 4'(b);
        set_flags = 1'(sf); cmp_test = 1'(ct); shift_used = 1'(su);
        shift_carry = 1'(sc); cond = 4'(cd);
        #0.5;
        chk("R2 exec_en", int'(exec_en), pred(cd));
        cn = mc; vn = mv;
        if (op <= 1) begin
            us = a + b + ((op == 1) ? mc : 0);
            ss = sgn(a) + sgn(b) + ((op == 1) ? mc : 0);
            r = us % 16; cn = (us > 15); vn = (ss > 7 || ss < -8);
        end else if (op <= 5) begin
            x  = (op >= 4) ? b : a;
            y  = (op >= 4) ? a : b;
            bw = (op == 3 || op == 5) ? (1 - mc) : 0;
            us = x - y - bw;
            ss = sgn(x) - sgn(y) - bw;
            r = (us + 32) % 16; cn = (us >= 0); vn = (ss > 7 || ss < -8);
        end else begin
            case (op)
                6: r = a & b;
                7: r = a ^ b;
                8: r = a | b;
                9: r = a & (15 - b);
                11: r = 15 - b;
                12: r = (a * b) % 16;
                default: r = b;
            endcase
            if (op != 12 && su != 0) cn = sc;
        end
        commit = vld && pred(cd);
        wr_f   = commit && (sf || ct);
        @(negedge clk);
        if (!commit)        rtag = "R9 result";
        else if (ct != 0)   rtag = "R8 result";
        else if (op <= 5)   rtag = "R3 result";
        else if (op == 12)  rtag = "R7 result";
        else if (op >= 13)  rtag = "R11 result";
        else                rtag = "R6 result";
        if (commit && !ct) m_res = r;
        chk(rtag, int'(result), m_res);
        if (!commit) begin
            chk("R9 flags", int'(flags), mn*8 + mz*4 + mc*2 + mv);
        end else if (!wr_f) begin
            chk("R10 flags", int'(flags), mn*8 + mz*4 + mc*2 + mv);
        end else begin
            mn = (r >= 8); mz = (r == 0);
            chk(ct ? "R8 NZ" : "R3 NZ", int'(flags[3:2]), mn*2 + mz);
            if (op <= 5) begin
                chk("R4 carry", int'(flags[1]), cn);
                chk("R5 overflow", int'(flags[0]), vn);
            end else if (op == 12) begin
                chk("R7 CV kept", int'(flags[1:0]), cn*2 + vn);
            end else begin
                chk(op >= 13 ? "R11 CV" : "R6 CV", int'(flags[1:0]), cn*2 + vn);
            end
            mc = cn; mv = vn;
        end
    endtask

    initial begin
        rst_n = 1'b0; op_valid = 1'b0; op_sel = '0; lhs = '0; rhs = '0;
        set_flags = 1'b0; cmp_test = 1'b0; shift_used = 1'b0;
        shift_carry = 1'b0; cond = 4'd14;
        m_res = 0; mn = 0; mz = 0; mc = 0; mv = 0;
        repeat (3) @(negedge clk);
        chk("R1 result", int'(result), 0);
        chk("R1 flags", int'(flags), 0);
        rst_n = 1'b1;
        // Never-condition with a valid op must not commit
        run_op(0, 5, 7, 1, 1, 0, 0, 0, 15);
        // Borrow corner: 0 - 1 sets N, clears C
        run_op(2, 0, 1, 1, 1, 0, 0, 0, 14);
        // Signed overflow corner: 7 + 1
        run_op(0, 7, 1, 1, 1, 0, 0, 0, 14);
        for (int op = 0; op < 16; op++)
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++)
                    run_op(op, a, b,
                           ((a + b) % 11 != 10),
                           ((a + b + op) % 3 != 0),
                           ((op == 0 || op == 2 || op == 6 || op == 7) && ((a*3 + b) % 5 == 0)),
                           b % 2, (a / 2) % 2,
                           (((a ^ b) % 2) == 0) ? 14 : (a + b + op) % 16);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule